// File: doc/BRIEF.md
# ADC Conversion Control Sequencer

This block runs one analog-to-digital conversion at a time on behalf of a host. The host writes a single control word that names the channel to convert, carries a per-channel enable mask, optionally requests a settling pause, and sets a start bit. The sequencer then waits out the pause (if asked), strobes an external converter, waits for the converter's completion pulse, captures its 16-bit sample into a result register and raises a completion flag in a status register. That flag is cleared by writing a one to it, and it can be routed onto an interrupt line through an enable register.

Ten channels exist. Channels 0 to 7 are signal inputs, channel 8 is the positive reference and channel 9 the zero reference; all ten are handled identically by the sequencer. A start for a channel whose enable bit is clear, or for a channel number of 10 or above, finishes without touching the converter and leaves zero in the result register. The result is readable in two views: as captured (two's complement) and with its top bit inverted (offset binary). The asynchronous reset is expected to be released synchronously to the clock by the surrounding reset logic.

Register map on the 3-bit address: 0 control word, 1 status, 2 interrupt enable, 3 result, 4 result in offset binary; other addresses read zero. Control word: bit 0 start, bits 4:1 channel number, bits 14:5 enable mask (bit 5 + n enables channel n), bit 15 settling-delay request. Status: bit 0 busy (read only), bit 2 conversion done.

Top module: `adc_seq_top`

## Requirements
- R1: After reset, status, result, control readback, interrupt enable, `irq` and `cnv_start` are all zero.
- R2: A write to address 0 with bit 0 set while idle is accepted: the word is latched and reads back at address 0, `cnv_chan` shows bits 4:1, and status bit 0 (busy) is 1 from the next cycle until completion.
- R3: For an enabled channel without delay, `cnv_start` is high for exactly one cycle, in the cycle right after the accepting clock edge.
- R4: With bit 15 set, the `cnv_start` pulse comes exactly `SETTLE_CYCLES` cycles later than it would without it.
- R5: On the clock edge where `cnv_done` is sampled high while waiting for the converter, `cnv_data` is loaded into the result register (address 3), busy clears and status bit 2 sets.
- R6: When the mask bit (bit 5 + channel) is clear or the channel number is 10 or more, no `cnv_start` is issued, the result register becomes zero and status bit 2 sets one cycle after acceptance; channels 8 and 9 convert normally when enabled.
- R7: A start written while busy is ignored: the latched word, `cnv_chan` and the running conversion are unchanged and only one conversion completes.
- R8: Writing status with bit 2 set clears the done flag; writes with bit 2 clear leave it unchanged; a clear in the same cycle as a completion leaves the flag set.
- R9: `irq` is high exactly when the done flag is set and bit 2 of the interrupt enable register (address 2) is set.
- R10: Address 4 reads the result with bit 15 inverted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_addr | input | 3 | Register address for read and write |
| reg_wr | input | 1 | Write strobe, one cycle per write |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data for `reg_addr`, combinational |
| irq | output | 1 | Interrupt: done flag gated by enable |
| cnv_start | output | 1 | One-cycle conversion start strobe to the converter |
| cnv_chan | output | 4 | Channel number of the latched control word |
| cnv_done | input | 1 | Converter completion pulse |
| cnv_data | input | 16 | Converter sample, valid with `cnv_done` |

## Verification
The completion of a conversion and a host write-one-to-clear of the done flag can land on the same clock edge. The bench provokes this by timing the clear write against its converter model's fixed latency so that `cnv_done` and the status write are both sampled on one edge, then reads the status register and expects the done flag still set; a following lone clear must then drop it. A second collision, a start word written while a delayed conversion is running, is judged by the latched word, the channel output and a single converter strobe.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;

  localparam int unsigned ADDR_W = 3;

  localparam logic [ADDR_W-1:0] A_CTRL  = 3'd0;
  localparam logic [ADDR_W-1:0] A_STAT  = 3'd1;
  localparam logic [ADDR_W-1:0] A_IEN   = 3'd2;
  localparam logic [ADDR_W-1:0] A_RES   = 3'd3;
  localparam logic [ADDR_W-1:0] A_RESOB = 3'd4;

  localparam int unsigned BUSY_BIT  = 0;
  localparam int unsigned DONE_BIT  = 2;
  localparam int unsigned START_BIT = 0;

  typedef enum logic [2:0] {
    S_IDLE,
    S_SETTLE,
    S_ISSUE,
    S_WAIT,
    S_NULL
  } seq_state_e;

endpackage

// File: rtl/adc_seq_regs.sv
module adc_seq_regs
  import adc_seq_pkg::*;
#(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned CTRL_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic              reg_wr,
  input  logic [DATA_W-1:0] reg_wdata,
  input  logic              busy,
  input  logic              done_set,
  input  logic [CTRL_W-1:0] ctrl_q,
  input  logic [DATA_W-1:0] result_q,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              start_req,
  output logic              done_q,
  output logic              irq
);

  localparam logic [DATA_W-1:0] SIGN_FLIP = {1'b1, {(DATA_W-1){1'b0}}};

  logic ien_q, ien_d, ien_en;
  logic done_d, done_en;
  logic clr_req;

  assign start_req = reg_wr && (reg_addr == A_CTRL) && reg_wdata[START_BIT];
  assign clr_req   = reg_wr && (reg_addr == A_STAT) && reg_wdata[DONE_BIT];

  // next-state: completion has priority over a same-cycle clear
  always_comb begin
    ien_en  = reg_wr && (reg_addr == A_IEN);
    ien_d   = reg_wdata[DONE_BIT];
    done_en = done_set || clr_req;
    done_d  = done_set;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ien_q  <= 1'b0;
      done_q <= 1'b0;
    end else begin
      if (ien_en)  ien_q  <= ien_d;
      if (done_en) done_q <= done_d;
    end
  end

  assign irq = done_q && ien_q;

  always_comb begin
    reg_rdata = '0;
    unique case (reg_addr)
      A_CTRL:  reg_rdata = DATA_W'(ctrl_q);
      A_STAT: begin
        reg_rdata[DONE_BIT] = done_q;
        reg_rdata[BUSY_BIT] = busy;
      end
      A_IEN:   reg_rdata[DONE_BIT] = ien_q;
      A_RES:   reg_rdata = result_q;
      A_RESOB: reg_rdata = result_q ^ SIGN_FLIP;
      default: reg_rdata = '0;
    endcase
  end

endmodule

// File: rtl/adc_seq_fsm.sv
module adc_seq_fsm
  import adc_seq_pkg::*;
#(
  parameter int unsigned NCHAN         = 10,
  parameter int unsigned CH_W          = 4,
  parameter int unsigned DATA_W        = 16,
  parameter int unsigned SETTLE_CYCLES = 8,
  parameter int unsigned CTRL_W        = CH_W + NCHAN + 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_req,
  input  logic [CTRL_W-1:0] start_word,
  input  logic              cnv_done,
  input  logic [DATA_W-1:0] cnv_data,
  output logic              cnv_start,
  output logic              busy,
  output logic              done_set,
  output logic [CTRL_W-1:0] ctrl_q,
  output logic [DATA_W-1:0] result_q
);

  localparam int unsigned CH_LO   = 1;
  localparam int unsigned MSK_LO  = CH_W + 1;
  localparam int unsigned DLY_BIT = CH_W + NCHAN + 1;
  localparam int unsigned CNT_W   = $clog2(SETTLE_CYCLES + 1);

  seq_state_e        st_q, st_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic              cnt_en, ctrl_en, res_en;
  logic [DATA_W-1:0] res_d;
  logic [CH_W-1:0]   new_chan;
  logic [NCHAN-1:0]  new_mask;
  logic [NCHAN-1:0]  chan_hit;
  logic              new_dly, new_en, accept;

  assign new_chan = start_word[CH_LO +: CH_W];
  assign new_mask = start_word[MSK_LO +: NCHAN];
  assign new_dly  = start_word[DLY_BIT];

  // one comparator per channel; numbers past the last channel match none
  for (genvar g = 0; g < NCHAN; g++) begin : g_hit
    assign chan_hit[g] = (new_chan == CH_W'(g)) && new_mask[g];
  end
  assign new_en = |chan_hit;

  assign accept = start_req && (st_q == S_IDLE);

  always_comb begin
    st_d    = st_q;
    cnt_en  = 1'b0;
    cnt_d   = cnt_q;
    ctrl_en = 1'b0;
    res_en  = 1'b0;
    res_d   = result_q;
    unique case (st_q)
      S_IDLE: begin
        if (accept) begin
          ctrl_en = 1'b1;
          if (!new_en) begin
            st_d = S_NULL;
          end else if (new_dly) begin
            st_d   = S_SETTLE;
            cnt_en = 1'b1;
            cnt_d  = CNT_W'(SETTLE_CYCLES);
          end else begin
            st_d = S_ISSUE;
          end
        end
      end
      S_SETTLE: begin
        cnt_en = 1'b1;
        cnt_d  = cnt_q - 1'b1;
        if (cnt_q == CNT_W'(1)) st_d = S_ISSUE;
      end
      S_ISSUE: st_d = S_WAIT;
      S_WAIT: begin
        if (cnv_done) begin
          res_en = 1'b1;
          res_d  = cnv_data;
          st_d   = S_IDLE;
        end
      end
      S_NULL: begin
        res_en = 1'b1;
        res_d  = '0;
        st_d   = S_IDLE;
      end
      default: st_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q     <= S_IDLE;
      cnt_q    <= '0;
      ctrl_q   <= '0;
      result_q <= '0;
    end else begin
      st_q <= st_d;
      if (cnt_en)  cnt_q    <= cnt_d;
      if (ctrl_en) ctrl_q   <= start_word;
      if (res_en)  result_q <= res_d;
    end
  end

  assign cnv_start = (st_q == S_ISSUE);
  assign busy      = (st_q != S_IDLE);
  assign done_set  = res_en;

endmodule

// File: rtl/adc_seq_top.sv
module adc_seq_top
  import adc_seq_pkg::*;
#(
  parameter int unsigned NCHAN         = 10,
  parameter int unsigned CH_W          = 4,
  parameter int unsigned DATA_W        = 16,
  parameter int unsigned SETTLE_CYCLES = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic              reg_wr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              irq,
  output logic              cnv_start,
  output logic [CH_W-1:0]   cnv_chan,
  input  logic              cnv_done,
  input  logic [DATA_W-1:0] cnv_data
);

  localparam int unsigned CTRL_W = CH_W + NCHAN + 2;

  logic              start_req, busy, done_set, done_q;
  logic [CTRL_W-1:0] ctrl_q;
  logic [DATA_W-1:0] result_q;

  adc_seq_fsm #(
    .NCHAN(NCHAN), .CH_W(CH_W), .DATA_W(DATA_W),
    .SETTLE_CYCLES(SETTLE_CYCLES), .CTRL_W(CTRL_W)
  ) u_fsm (
    .clk(clk), .rst_n(rst_n),
    .start_req(start_req), .start_word(reg_wdata[CTRL_W-1:0]),
    .cnv_done(cnv_done), .cnv_data(cnv_data),
    .cnv_start(cnv_start), .busy(busy), .done_set(done_set),
    .ctrl_q(ctrl_q), .result_q(result_q)
  );

  adc_seq_regs #(.DATA_W(DATA_W), .CTRL_W(CTRL_W)) u_regs (
    .clk(clk), .rst_n(rst_n),
    .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
    .busy(busy), .done_set(done_set), .ctrl_q(ctrl_q), .result_q(result_q),
    .reg_rdata(reg_rdata), .start_req(start_req), .done_q(done_q), .irq(irq)
  );

  assign cnv_chan = ctrl_q[1 +: CH_W];

endmodule

// File: rtl/adc_seq_chk.sv
module adc_seq_chk #(
  parameter int unsigned CH_W   = 4,
  parameter int unsigned DATA_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic [2:0]        reg_addr,
  input logic              reg_wr,
  input logic [DATA_W-1:0] reg_wdata,
  input logic              cnv_start,
  input logic [CH_W-1:0]   cnv_chan,
  input logic              busy,
  input logic              done,
  input logic              irq
);

  assert_strobe_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
    cnv_start |-> busy);

  assert_strobe_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
    cnv_start |=> !cnv_start);

  assert_done_on_finish_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done);

  assert_ignore_busy_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == 3'd0 && reg_wdata[0] && busy) |=> $stable(cnv_chan));

  assert_clear_only_w1c_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(done) |-> $past(reg_wr && reg_addr == 3'd1 && reg_wdata[2]));

  assert_irq_needs_done_R9: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> done);

endmodule

bind adc_seq_top adc_seq_chk #(.CH_W(CH_W), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
  .reg_wdata(reg_wdata), .cnv_start(cnv_start), .cnv_chan(cnv_chan),
  .busy(busy), .done(done_q), .irq(irq)
);

// File: tb/adc_seq_top_tb.sv
module adc_seq_top_tb;

  localparam int CLK_PERIOD = 10;
  localparam int SETTLE     = 8;
  localparam int LAT        = 3;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [2:0]  reg_addr;
  logic        reg_wr;
  logic [15:0] reg_wdata;
  logic [15:0] reg_rdata;
  logic        irq, cnv_start, cnv_done;
  logic [3:0]  cnv_chan;
  logic [15:0] cnv_data;

  int tests = 0, fails = 0, cyc = 0;
  int starts = 0, start_cyc = 0, pend = 0;
  logic [15:0] conv_val = 16'h0;

  adc_seq_top #(.SETTLE_CYCLES(SETTLE)) u_dut (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq),
    .cnv_start(cnv_start), .cnv_chan(cnv_chan),
    .cnv_done(cnv_done), .cnv_data(cnv_data)
  );

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc++;

  // converter model: done pulse LAT cycles after the strobe is seen
  initial begin
    cnv_done = 1'b0;
    cnv_data = 16'h0;
    forever begin
      @(negedge clk);
      if (cnv_done) cnv_done = 1'b0;
      else if (pend > 0) begin
        pend--;
        if (pend == 0) begin
          cnv_done = 1'b1;
          cnv_data = conv_val;
        end
      end
      if (cnv_start) begin
        starts++;
        start_cyc = cyc;
        pend = LAT;
      end
    end
  end

  function automatic logic [15:0] mk(int ch, logic [9:0] msk, logic dly);
    logic [3:0] c = ch[3:0];
    return {dly, msk, c, 1'b1};
  endfunction

  function automatic logic [15:0] exp_res(int ch, logic [9:0] msk, logic [15:0] v);
    if (ch < 10 && msk[ch]) return v;
    return 16'h0;
  endfunction

  task automatic chk(bit ok, string req, int act, int expv);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, expv);
    end
  endtask

  task automatic wr(logic [2:0] a, logic [15:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0; reg_wdata = 16'h0;
  endtask

  task automatic rd(logic [2:0] a, output logic [15:0] v);
    reg_addr = a;
    #1;
    v = reg_rdata;
  endtask

  task automatic wait_idle();
    logic [15:0] v;
    for (int k = 0; k < 300; k++) begin
      @(negedge clk);
      rd(3'd1, v);
      if (!v[0]) break;
    end
  endtask

  task automatic expect_rd(logic [2:0] a, logic [15:0] e, string req);
    logic [15:0] v;
    rd(a, v);
    chk(v === e, req, int'(v), int'(e));
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    logic [15:0] v;
    int s0, cw;
    void'($urandom(32'd4242));
    rst_n = 1'b0; reg_addr = 3'd0; reg_wr = 1'b0; reg_wdata = 16'h0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    expect_rd(3'd1, 16'h0, "R1 status");
    expect_rd(3'd3, 16'h0, "R1 result");
    expect_rd(3'd0, 16'h0, "R1 ctrl");
    expect_rd(3'd2, 16'h0, "R1 ien");
    chk(irq === 1'b0 && cnv_start === 1'b0, "R1 outputs", {irq, cnv_start}, 0);

    // R2 R3 R5 enabled channel, no delay
    conv_val = 16'h1234; s0 = starts;
    wr(3'd0, mk(3, 10'h008, 1'b0)); cw = cyc;
    chk(cnv_chan === 4'd3, "R2 cnv_chan", cnv_chan, 3);
    expect_rd(3'd1, 16'h0001, "R2 busy");
    expect_rd(3'd0, mk(3, 10'h008, 1'b0), "R2 ctrl readback");
    wait_idle();
    chk(start_cyc - cw == 0, "R3 strobe cycle", start_cyc - cw, 0);
    chk(starts - s0 == 1, "R3 single strobe", starts - s0, 1);
    expect_rd(3'd3, 16'h1234, "R5 result");
    expect_rd(3'd1, 16'h0004, "R5 done");
    expect_rd(3'd4, 16'h9234, "R10 offset binary");
    chk(irq === 1'b0, "R9 irq masked", irq, 0);
    wr(3'd2, 16'h0004);
    expect_rd(3'd2, 16'h0004, "R9 ien readback");
    chk(irq === 1'b1, "R9 irq enabled", irq, 1);
    wr(3'd1, 16'hFFFB);
    expect_rd(3'd1, 16'h0004, "R8 other bits ignored");
    wr(3'd1, 16'h0004);
    expect_rd(3'd1, 16'h0000, "R8 w1c clears");
    chk(irq === 1'b0, "R9 irq after clear", irq, 0);

    // R4 settling delay
    conv_val = 16'h8001;
    wr(3'd0, mk(5, 10'h020, 1'b1)); cw = cyc;
    wait_idle();
    chk(start_cyc - cw == SETTLE, "R4 delay", start_cyc - cw, SETTLE);
    expect_rd(3'd3, 16'h8001, "R5 result delayed");
    expect_rd(3'd4, 16'h0001, "R10 offset binary neg");
    chk(irq === 1'b1, "R9 irq on done", irq, 1);
    wr(3'd1, 16'h0004);

    // R6 disabled channel
    s0 = starts;
    wr(3'd0, mk(2, 10'h3FB, 1'b0));
    expect_rd(3'd1, 16'h0001, "R6 busy one cycle");
    @(negedge clk);
    expect_rd(3'd1, 16'h0004, "R6 done next cycle");
    expect_rd(3'd3, 16'h0000, "R6 result zero");
    chk(starts == s0, "R6 no strobe", starts - s0, 0);
    wr(3'd1, 16'h0004);

    // R6 reference channel 9 converts, then channel 12 gives zero
    conv_val = 16'h7FFF;
    wr(3'd0, mk(9, 10'h200, 1'b0));
    wait_idle();
    expect_rd(3'd3, 16'h7FFF, "R6 reference channel");
    wr(3'd1, 16'h0004);
    s0 = starts;
    wr(3'd0, mk(12, 10'h3FF, 1'b0));
    wait_idle();
    expect_rd(3'd3, 16'h0000, "R6 channel out of range");
    chk(starts == s0, "R6 out of range no strobe", starts - s0, 0);
    wr(3'd1, 16'h0004);

    // R7 start while busy
    conv_val = 16'h4444; s0 = starts;
    wr(3'd0, mk(1, 10'h002, 1'b1));
    wr(3'd0, mk(6, 10'h3FF, 1'b0));
    chk(cnv_chan === 4'd1, "R7 channel kept", cnv_chan, 1);
    expect_rd(3'd0, mk(1, 10'h002, 1'b1), "R7 word kept");
    wait_idle();
    chk(starts - s0 == 1, "R7 one conversion", starts - s0, 1);
    expect_rd(3'd3, 16'h4444, "R7 result");
    wr(3'd1, 16'h0004);

    // R8 completion and clear on the same edge
    conv_val = 16'h5A5A;
    wr(3'd0, mk(4, 10'h010, 1'b0));
    repeat (2) @(negedge clk);
    wr(3'd1, 16'h0004);
    expect_rd(3'd1, 16'h0004, "R8 set wins");
    expect_rd(3'd3, 16'h5A5A, "R5 result at collision");
    wr(3'd1, 16'h0004);
    expect_rd(3'd1, 16'h0000, "R8 later clear");

    // random mix
    for (int it = 0; it < 40; it++) begin
      int ch;
      logic [9:0] msk;
      logic dly;
      logic [15:0] e;
      ch = int'($urandom_range(0, 11));
      msk = 10'($urandom);
      dly = 1'($urandom_range(0, 1));
      conv_val = 16'($urandom);
      e = exp_res(ch, msk, conv_val);
      s0 = starts;
      wr(3'd0, mk(ch, msk, dly));
      wait_idle();
      expect_rd(3'd3, e, "R5 R6 random result");
      expect_rd(3'd4, e ^ 16'h8000, "R10 random offset");
      expect_rd(3'd1, 16'h0004, "R5 random done");
      chk(starts - s0 == ((ch < 10 && msk[ch]) ? 1 : 0), "R6 random strobe count",
          starts - s0, (ch < 10 && msk[ch]) ? 1 : 0);
      chk(irq === 1'b1, "R9 random irq", irq, 1);
      wr(3'd1, 16'h0004);
    end

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule